// File: doc/BRIEF.md
# System clock source selector

This block keeps the clock configuration of a chip and decides which oscillator drives the system clock. The system clock comes from one of two places. The first is a low-speed oscillator. The second is a high-speed clock, which is fed in turn by an internal oscillator or by an external high-speed oscillator. Software reaches the configuration through a small register port with separate write and read strobes. The analog oscillators return one ready flag each. From these the block drives a system/high-speed select pair, a gated enable for each oscillator, and a sticky error flag.

Every configuration write is screened before it is accepted. A write that would switch off the oscillator now running the system clock is refused. A change of the high-speed source is refused unless the peripheral clock enable field is at its full value. A read of the source register on the access straight after a write to that register is also refused. The select outputs never move to an oscillator that is not both enabled and ready, so an external clock multiplexer that follows them only ever switches between running sources. A sleep input stops all oscillators and leaves every setting as it was.

Top module: `clksel_top`

## Requirements
- R1: After reset the select outputs are 0 and 0 (system clock from the high-speed clock, high-speed clock from the internal oscillator). The low-speed and internal enables are 1, the external enable is 0, and the error flag is 0.
- R2: Register 0 holds two request bits: bit 0 selects the system source (0 high-speed, 1 low-speed) and bit 1 selects the high-speed source (0 internal, 1 external). Reading it also returns the active system select in bit 2 and the active high-speed select in bit 3. Read data appears on rdata_o in the cycle after the read strobe and holds until the next read.
- R3: A write to register 0 that changes bit 1 is accepted only when register 2 bits 1:0 equal 3. Otherwise the whole write is ignored and the error flag is set.
- R4: Register 1 holds the enables in bit 0 (low-speed), bit 1 (internal) and bit 2 (external). A write that clears the enable of the oscillator now driving the system clock is ignored as a whole and sets the error flag.
- R5: A read of register 0 whose previous access, with idle cycles not counted, was a write to register 0 is refused. It returns 0 and sets the error flag. Any other access in between allows the read.
- R6: The system select output takes the requested value one cycle after a clock edge at which the target oscillator is enabled and ready. Until then it keeps its old value.
- R7: The high-speed select output follows its request under the same rule as R6, with the internal or external oscillator as the target.
- R8: The error flag stays set until a write to register 3 with bit 0 at 1 clears it. A write to register 3 with bit 0 at 0 has no effect.
- R9: While sleep_i is 1, all three enable outputs are 0. Register contents and select outputs are kept, and the enables return to their register values once sleep_i falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register index |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid one cycle after the read strobe |
| lo_rdy_i | input | 1 | Low-speed oscillator ready |
| int_rdy_i | input | 1 | Internal high-speed oscillator ready |
| ext_rdy_i | input | 1 | External high-speed oscillator ready |
| sleep_i | input | 1 | Sleep request, stops all oscillators |
| sys_sel_o | output | 1 | Active system source: 0 high-speed clock, 1 low-speed oscillator |
| hs_sel_o | output | 1 | Active high-speed source: 0 internal, 1 external |
| lo_en_o | output | 1 | Low-speed oscillator enable |
| int_en_o | output | 1 | Internal oscillator enable |
| ext_en_o | output | 1 | External oscillator enable |
| err_o | output | 1 | Sticky error flag for refused accesses |

## Verification
The assertions assume that write and read strobes never arrive in the same cycle. They also assume that a select output can rise or fall only after the matching ready input was high at the edge before. The stimulus keeps the two strobes apart and drives the ready flags only at falling edges. The assertions also rely on the oscillator that feeds the active source staying enabled whenever sleep is low. This holds because the stimulus disables an oscillator only after the selection has moved away from it.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int NOSC = 3;

    localparam logic [1:0] OSC_LO  = 2'd0;
    localparam logic [1:0] OSC_INT = 2'd1;
    localparam logic [1:0] OSC_EXT = 2'd2;

    // enables after reset: low-speed and internal running, external off
    localparam logic [NOSC-1:0] EN_RESET = 3'b011;

    typedef enum logic [1:0] {
        A_SRC  = 2'd0,
        A_EN   = 2'd1,
        A_PCLK = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // oscillator that presently drives the system clock
    function automatic logic [1:0] active_osc(input logic sys_act, input logic hs_act);
        if (sys_act) return OSC_LO;
        return hs_act ? OSC_EXT : OSC_INT;
    endfunction

endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
    import clksel_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PCLK_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   wdata,
    input  logic            act_sys,
    input  logic            act_hs,
    output logic            req_sys,
    output logic            req_hs,
    output logic [NOSC-1:0] osc_en,
    output logic            err,
    output logic [DW-1:0]   rdata
);

    localparam logic [PCLK_W-1:0] PCLK_FULL = {PCLK_W{1'b1}};

    typedef struct packed {
        logic              req_sys;
        logic              req_hs;
        logic [NOSC-1:0]   en;
        logic [PCLK_W-1:0] pclk;
        logic              err;
        logic              last_src_wr;
        logic [DW-1:0]     rdata;
    } regs_t;

    regs_t      q, d;
    logic [1:0] act_idx;
    logic       unused_wdata;

    assign unused_wdata = ^wdata[DW-1:3];

    always_comb begin
        d       = q;
        act_idx = active_osc(act_sys, act_hs);
        if (wr_en) begin
            d.last_src_wr = (addr == A_SRC);
            case (reg_addr_e'(addr))
                A_SRC: begin
                    if ((wdata[1] != q.req_hs) && (q.pclk != PCLK_FULL)) begin
                        d.err = 1'b1;
                    end else begin
                        d.req_sys = wdata[0];
                        d.req_hs  = wdata[1];
                    end
                end
                A_EN: begin
                    if (!wdata[act_idx]) d.err = 1'b1;
                    else                 d.en  = wdata[NOSC-1:0];
                end
                A_PCLK: d.pclk = wdata[PCLK_W-1:0];
                A_STAT: if (wdata[0]) d.err = 1'b0;
                default: ;
            endcase
        end else if (rd_en) begin
            d.last_src_wr = 1'b0;
            d.rdata       = '0;
            case (reg_addr_e'(addr))
                A_SRC: begin
                    if (q.last_src_wr) d.err = 1'b1;
                    else d.rdata[3:0] = {act_hs, act_sys, q.req_hs, q.req_sys};
                end
                A_EN:    d.rdata[NOSC-1:0]   = q.en;
                A_PCLK:  d.rdata[PCLK_W-1:0] = q.pclk;
                A_STAT:  d.rdata[0]          = q.err;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{req_sys: 1'b0, req_hs: 1'b0, en: EN_RESET, pclk: '0,
                   err: 1'b0, last_src_wr: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_sys = q.req_sys;
    assign req_hs  = q.req_hs;
    assign osc_en  = q.en;
    assign err     = q.err;
    assign rdata   = q.rdata;

endmodule

// File: rtl/clksel_switch.sv
module clksel_switch
    import clksel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_sys,
    input  logic            req_hs,
    input  logic [NOSC-1:0] osc_en,
    input  logic [NOSC-1:0] osc_rdy,
    output logic            act_sys,
    output logic            act_hs
);

    typedef struct packed {
        logic sys;
        logic hs;
    } sel_t;

    sel_t            q, d;
    logic [NOSC-1:0] usable;
    logic [1:0]      sys_tgt;
    logic [1:0]      hs_tgt;

    for (genvar i = 0; i < NOSC; i++) begin : g_usable
        assign usable[i] = osc_en[i] & osc_rdy[i];
    end

    always_comb begin
        d       = q;
        sys_tgt = req_sys ? OSC_LO : (q.hs ? OSC_EXT : OSC_INT);
        hs_tgt  = req_hs ? OSC_EXT : OSC_INT;
        if ((req_sys != q.sys) && usable[sys_tgt]) d.sys = req_sys;
        if ((req_hs != q.hs) && usable[hs_tgt])    d.hs  = req_hs;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sys: 1'b0, hs: 1'b0};
        else        q <= d;
    end

    assign act_sys = q.sys;
    assign act_hs  = q.hs;

endmodule

// File: rtl/clksel_top.sv
module clksel_top
    import clksel_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PCLK_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          lo_rdy_i,
    input  logic          int_rdy_i,
    input  logic          ext_rdy_i,
    input  logic          sleep_i,
    output logic          sys_sel_o,
    output logic          hs_sel_o,
    output logic          lo_en_o,
    output logic          int_en_o,
    output logic          ext_en_o,
    output logic          err_o
);

    logic            req_sys, req_hs, act_sys, act_hs;
    logic [NOSC-1:0] reg_en, osc_rdy, gated_en;

    assign osc_rdy = {ext_rdy_i, int_rdy_i, lo_rdy_i};

    clksel_regs #(.DW(DW), .PCLK_W(PCLK_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .rd_en   (rd_en_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .act_sys (act_sys),
        .act_hs  (act_hs),
        .req_sys (req_sys),
        .req_hs  (req_hs),
        .osc_en  (reg_en),
        .err     (err_o),
        .rdata   (rdata_o)
    );

    clksel_switch switch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_sys (req_sys),
        .req_hs  (req_hs),
        .osc_en  (reg_en),
        .osc_rdy (osc_rdy),
        .act_sys (act_sys),
        .act_hs  (act_hs)
    );

    for (genvar i = 0; i < NOSC; i++) begin : g_gate
        assign gated_en[i] = reg_en[i] & ~sleep_i;
    end

    assign lo_en_o   = gated_en[OSC_LO];
    assign int_en_o  = gated_en[OSC_INT];
    assign ext_en_o  = gated_en[OSC_EXT];
    assign sys_sel_o = act_sys;
    assign hs_sel_o  = act_hs;

endmodule

// File: rtl/clksel_chk.sv
module clksel_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [1:0]    addr_i,
    input logic [DW-1:0] wdata_i,
    input logic          lo_rdy_i,
    input logic          int_rdy_i,
    input logic          ext_rdy_i,
    input logic          sleep_i,
    input logic          sys_sel_o,
    input logic          hs_sel_o,
    input logic          lo_en_o,
    input logic          int_en_o,
    input logic          ext_en_o,
    input logic          err_o
);

    p_lo_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && sys_sel_o) |-> lo_en_o);

    p_int_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !sys_sel_o && !hs_sel_o) |-> int_en_o);

    p_ext_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !sys_sel_o && hs_sel_o) |-> ext_en_o);

    p_sys_to_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_sel_o) |-> $past(lo_rdy_i));

    p_hs_to_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_sel_o) |-> $past(ext_rdy_i));

    p_hs_to_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_sel_o) |-> $past(int_rdy_i));

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(wr_en_i && (addr_i == 2'd3) && wdata_i[0]));

endmodule

bind clksel_top clksel_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .lo_rdy_i  (lo_rdy_i),
    .int_rdy_i (int_rdy_i),
    .ext_rdy_i (ext_rdy_i),
    .sleep_i   (sleep_i),
    .sys_sel_o (sys_sel_o),
    .hs_sel_o  (hs_sel_o),
    .lo_en_o   (lo_en_o),
    .int_en_o  (int_en_o),
    .ext_en_o  (ext_en_o),
    .err_o     (err_o)
);

// File: tb/clksel_top_tb_top.sv
`timescale 1ns/1ps
module clksel_top_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [1:0]    addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          lo_rdy_i = 1'b1, int_rdy_i = 1'b1, ext_rdy_i = 1'b0;
    logic          sleep_i = 1'b0;
    logic          sys_sel_o, hs_sel_o, lo_en_o, int_en_o, ext_en_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clksel_top #(.DW(DW), .PCLK_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .lo_rdy_i(lo_rdy_i), .int_rdy_i(int_rdy_i), .ext_rdy_i(ext_rdy_i),
        .sleep_i(sleep_i), .sys_sel_o(sys_sel_o), .hs_sel_o(hs_sel_o),
        .lo_en_o(lo_en_o), .int_en_o(int_en_o), .ext_en_o(ext_en_o),
        .err_o(err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_rq_sys, m_rq_hs, m_sys, m_hs, m_pclk, m_err, m_rdata, m_last;
    int m_en[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rq_sys = 0; m_rq_hs = 0; m_sys = 0; m_hs = 0; m_pclk = 0;
            m_err = 0; m_rdata = 0; m_last = 0;
            m_en[0] = 1; m_en[1] = 1; m_en[2] = 0;
        end else begin
            int rdy[3];
            int o_sys, o_hs, running, tgt;
            rdy[0] = lo_rdy_i; rdy[1] = int_rdy_i; rdy[2] = ext_rdy_i;
            o_sys = m_sys; o_hs = m_hs;
            running = o_sys ? 0 : (o_hs ? 2 : 1);
            if (m_rq_sys != o_sys) begin
                tgt = m_rq_sys ? 0 : (o_hs ? 2 : 1);
                if (m_en[tgt] != 0 && rdy[tgt] != 0) m_sys = m_rq_sys;
            end
            if (m_rq_hs != o_hs) begin
                tgt = m_rq_hs ? 2 : 1;
                if (m_en[tgt] != 0 && rdy[tgt] != 0) m_hs = m_rq_hs;
            end
            if (wr_en_i) begin
                m_last = (addr_i == 0);
                if (addr_i == 0) begin
                    if (int'(wdata_i[1]) != m_rq_hs && m_pclk != 3) m_err = 1;
                    else begin m_rq_sys = wdata_i[0]; m_rq_hs = wdata_i[1]; end
                end else if (addr_i == 1) begin
                    if (wdata_i[running] == 1'b0) m_err = 1;
                    else for (int k = 0; k < 3; k++) m_en[k] = wdata_i[k];
                end else if (addr_i == 2) m_pclk = wdata_i[1:0];
                else if (wdata_i[0]) m_err = 0;
            end else if (rd_en_i) begin
                if (addr_i == 0) begin
                    if (m_last) begin m_rdata = 0; m_err = 1; end
                    else m_rdata = m_rq_sys + 2*m_rq_hs + 4*o_sys + 8*o_hs;
                end else if (addr_i == 1) m_rdata = m_en[0] + 2*m_en[1] + 4*m_en[2];
                else if (addr_i == 2) m_rdata = m_pclk;
                else m_rdata = m_err;
                m_last = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 sys_sel vs model", sys_sel_o, m_sys);
            chk("R7 hs_sel vs model", hs_sel_o, m_hs);
            chk("R9 lo_en vs model", lo_en_o, m_en[0] & int'(!sleep_i));
            chk("R4 int_en vs model", int_en_o, m_en[1] & int'(!sleep_i));
            chk("R4 ext_en vs model", ext_en_o, m_en[2] & int'(!sleep_i));
            chk("R8 err vs model", err_o, m_err);
            chk("R2 rdata vs model", rdata_o, m_rdata);
        end
    end

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = 2'(a); wdata_i = DW'(v);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = 2'(a);
        @(negedge clk);
        rd_en_i = 1'b0;
        v = rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sys_sel", sys_sel_o, 0);
        chk("R1 hs_sel", hs_sel_o, 0);
        chk("R1 lo_en", lo_en_o, 1);
        chk("R1 int_en", int_en_o, 1);
        chk("R1 ext_en", ext_en_o, 0);
        chk("R1 err", err_o, 0);

        // R2 / R6: move system clock to low-speed oscillator
        wr(0, 1);
        idle(1);
        chk("R6 sys_sel low", sys_sel_o, 1);
        rd(2, v);
        rd(0, v);
        chk("R2 src readback", v, 5);

        // R5: read straight after write is refused
        wr(0, 0);
        rd(0, v);
        chk("R5 refused data", v, 0);
        chk("R5 refused err", err_o, 1);
        chk("R7 hs_sel stays", hs_sel_o, 0);

        // R8: sticky flag, clear on write of 1
        wr(3, 0);
        chk("R8 err kept", err_o, 1);
        wr(3, 1);
        chk("R8 err cleared", err_o, 0);

        // R3: high-speed source change without full peripheral enable
        wr(0, 2);
        chk("R3 reject err", err_o, 1);
        rd(2, v);
        rd(0, v);
        chk("R3 request kept", v, 0);
        wr(3, 1);

        // R4: internal oscillator is active, cannot be disabled
        wr(1, 5);
        chk("R4 reject err", err_o, 1);
        chk("R4 int kept", int_en_o, 1);
        chk("R4 ext untouched", ext_en_o, 0);
        wr(3, 1);
        wr(1, 7);
        chk("R4 ext enabled", ext_en_o, 1);

        // R7: switch high-speed source, wait for ready
        wr(2, 3);
        wr(0, 2);
        chk("R3 accepted err", err_o, 0);
        idle(3);
        chk("R7 hs_sel waits", hs_sel_o, 0);
        ext_rdy_i = 1'b1;
        idle(2);
        chk("R7 hs_sel ext", hs_sel_o, 1);
        wr(1, 5);
        chk("R4 int now off", int_en_o, 0);
        chk("R4 no err", err_o, 0);

        // R6: system switch waits for low-speed ready
        lo_rdy_i = 1'b0;
        wr(0, 3);
        idle(3);
        chk("R6 sys_sel waits", sys_sel_o, 0);
        lo_rdy_i = 1'b1;
        idle(2);
        chk("R6 sys_sel low again", sys_sel_o, 1);
        wr(1, 1);
        chk("R4 ext now off", ext_en_o, 0);
        wr(1, 0);
        chk("R4 lo kept", lo_en_o, 1);
        chk("R4 lo reject err", err_o, 1);
        wr(3, 1);

        // R9: sleep stops oscillators, keeps configuration
        sleep_i = 1'b1;
        idle(2);
        chk("R9 lo off in sleep", lo_en_o, 0);
        chk("R9 sel kept in sleep", sys_sel_o, 1);
        sleep_i = 1'b0;
        idle(1);
        chk("R9 lo restored", lo_en_o, 1);
        chk("R9 hs_sel kept", hs_sel_o, 1);
        rd(2, v);
        rd(0, v);
        chk("R9 src kept", v, 15);
        idle(3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule